// File: doc/BRIEF.md
# Bilinear Bayer-to-RGB Demosaic

This block accepts a raster stream of raw colour-mosaic samples, one sample per position, and returns a full red, green and blue triple for every position. It uses bilinear interpolation. Each missing colour at a site is the truncated mean of the two or four nearest samples of that colour in the surrounding 3×3 neighbourhood. Two row stores, each one line long, hold the two previous lines. Two column registers and the incoming column then form the 3×3 window.

A phase tracker follows the mosaic site of the pixel at the window centre, and that site decides which neighbour averages go to each channel. The line length, frame height, sample width and mosaic start phase are elaboration-time parameters. Both sides use valid/ready streams. The input carries a start-of-frame flag. The output carries start-of-frame and end-of-line flags.

The result for a pixel can only be formed once the sample one line below it and one column to its right has arrived. The final line of a frame therefore needs extra work. After the last input sample, the block runs WIDTH+1 internal drain beats with its input closed, and these beats flush that line using edge replication.

Top module: `demosaic_bilinear`

## Requirements
- R1: Each frame of WIDTH×HEIGHT accepted samples, opened by an input start-of-frame flag, yields exactly WIDTH×HEIGHT output pixels in raster order.
- R2: At a red site the red output is the centre sample. Green is the sum of the four edge-adjacent neighbours shifted right by 2. Blue is the sum of the four diagonal neighbours shifted right by 2.
- R3: At a green site, green is the centre sample. On a line that holds red samples, red is the left/right pair summed and shifted right by 1, and blue is the up/down pair summed and shifted right by 1. On a line that holds blue samples, the two pairs swap roles.
- R4: At a blue site the blue output is the centre sample. Green is the edge-adjacent four-average, and red is the diagonal four-average, both truncated.
- R5: PHASE gives the position of the red sample inside the 2×2 tile at the top-left of the frame, as {row bit, column bit}: 0 = R G / G B, 1 = G R / B G, 2 = G B / R G, 3 = B G / G R. The site type alternates on every pixel and on every line.
- R6: A neighbour outside the frame takes the value of the nearest in-frame sample in the same column (top and bottom edges) or the same row (left and right edges). Corners apply both rules.
- R7: With no stalls, output pixel k (raster index) is presented in the cycle after input sample k+WIDTH+1 is accepted. Once the last sample of a frame is accepted, in_ready stays low for exactly WIDTH+1 cycles while the final line drains.
- R8: While out_valid is high and out_ready is low, the output pixel and its flags hold steady and in_ready is low. With no stalls, one sample is accepted every cycle.
- R9: out_sof is high only on pixel (0,0). out_eol is high exactly on the last pixel of each line.
- R10: Samples accepted without a start-of-frame flag while no frame is open are dropped and produce no output. A start-of-frame flag on any accepted sample restarts the frame at position (0,0).
- R11: During reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_pix | input | DW | Raw mosaic sample |
| in_sof | input | 1 | Marks the first sample of a frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel this cycle |
| out_red | output | DW | Red channel |
| out_grn | output | DW | Green channel |
| out_blu | output | DW | Blue channel |
| out_sof | output | 1 | First pixel of the frame |
| out_eol | output | 1 | Last pixel of a line |

## Verification
The bench drives each frame into two instances with different start phases and compares every output pixel against a reference model with clamped indexing. A wrong site selection or a swapped G-line pair shows up as channel errors in the interior, and a replication slip shows up only on the edge rows and columns. An all-full-scale frame catches sums that are too narrow, since they would wrap to small values. A stall-free frame times every pixel against the one-line-plus-one latency and counts the closed-input drain cycles, so an off-by-one in the drain length either loses the bottom-right pixel or lets a sample in during the flush. Samples sent with no frame open, and a short aborted frame restarted by a new start flag, must produce nothing extra.

// File: rtl/bayer_pkg.sv
package bayer_pkg;
  timeunit 1ns; timeprecision 1ps;

  // Position of the red sample inside the top-left 2x2 tile: {row, col}
  typedef enum logic [1:0] {
    PH_RGGB = 2'd0,
    PH_GRBG = 2'd1,
    PH_GBRG = 2'd2,
    PH_BGGR = 2'd3
  } bayer_phase_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    SITE_RED   = 2'd0,
    SITE_G_RLN = 2'd1,
    SITE_G_BLN = 2'd2,
    SITE_BLUE  = 2'd3
  } site_e;
endpackage

// File: rtl/demosaic_seq.sv
module demosaic_seq #(
  parameter int WIDTH  = 8,
  parameter int HEIGHT = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sof,
  input  logic                        space,
  output logic                        in_ready,
  output logic                        beat,
  output logic [$clog2(WIDTH)-1:0]    cur_col,
  output logic                        emit,
  output logic                        ctr_row_odd,
  output logic                        ctr_col_odd,
  output logic                        ctr_sof,
  output logic                        ctr_eol,
  output logic                        top_rep,
  output logic                        bot_rep,
  output logic                        left_rep,
  output logic                        right_rep
);
  timeunit 1ns; timeprecision 1ps;
  import bayer_pkg::*;

  localparam int CW = $clog2(WIDTH);
  localparam int RW = $clog2(HEIGHT + 2);
  localparam logic [CW-1:0] COL_LAST  = CW'(WIDTH - 1);
  localparam logic [RW-1:0] ROW_LAST  = RW'(HEIGHT - 1);
  localparam logic [RW-1:0] ROW_GHOST = RW'(HEIGHT);
  localparam logic [RW-1:0] ROW_END   = RW'(HEIGHT + 1);
  localparam logic          LAST_COL_ODD = ((WIDTH - 1) % 2) == 1;

  seq_state_e        state_q, state_d;
  logic [RW-1:0]     row_q, row_d, cur_row;
  logic [CW-1:0]     col_q, col_d;
  logic              accept, start;

  // Next-state logic
  always_comb begin
    in_ready = (state_q != SEQ_DRAIN) && space;
    accept   = in_valid && in_ready;
    start    = accept && in_sof;
    beat     = start || (accept && (state_q == SEQ_RUN)) ||
               ((state_q == SEQ_DRAIN) && space);
    cur_row  = start ? '0 : row_q;
    cur_col  = start ? '0 : col_q;

    emit = beat && (((cur_row != '0) && (cur_col != '0)) ||
                    ((cur_row > RW'(1)) && (cur_col == '0)));

    // Centre of the emitted window: (row-1, col-1), or (row-2, WIDTH-1) at col 0
    ctr_row_odd = (cur_col == '0) ? cur_row[0] : ~cur_row[0];
    ctr_col_odd = (cur_col == '0) ? LAST_COL_ODD : ~cur_col[0];
    ctr_sof     = (cur_row == RW'(1)) && (cur_col == CW'(1));
    ctr_eol     = (cur_col == '0);

    // Replication flags for the incoming column (centre row = cur_row-1)
    top_rep   = (cur_row == RW'(1));
    bot_rep   = (cur_row == ROW_GHOST);
    left_rep  = (cur_col == CW'(1));
    right_rep = (cur_col == '0);

    row_d = row_q;
    col_d = col_q;
    if (beat) begin
      if (cur_col == COL_LAST) begin
        col_d = '0;
        row_d = cur_row + RW'(1);
      end else begin
        col_d = cur_col + CW'(1);
        row_d = cur_row;
      end
    end

    state_d = state_q;
    if (beat && (cur_row == ROW_LAST) && (cur_col == COL_LAST)) state_d = SEQ_DRAIN;
    else if (beat && (cur_row == ROW_END))                      state_d = SEQ_IDLE;
    else if (start)                                             state_d = SEQ_RUN;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      if (beat) begin
        row_q <= row_d;
        col_q <= col_d;
      end
    end
  end
endmodule

// File: rtl/demosaic_window.sv
module demosaic_window #(
  parameter int WIDTH = 8,
  parameter int DW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          beat,
  input  logic [$clog2(WIDTH)-1:0]      cur_col,
  input  logic [DW-1:0]                 pix,
  input  logic                          top_rep,
  input  logic                          bot_rep,
  input  logic                          left_rep,
  input  logic                          right_rep,
  output logic [2:0][2:0][DW-1:0]       win      // [row][col], row 0 = top, col 0 = left
);
  timeunit 1ns; timeprecision 1ps;

  logic [DW-1:0]       lb_near [WIDTH];  // line above the incoming one
  logic [DW-1:0]       lb_far  [WIDTH];  // two lines above
  logic [2:0][DW-1:0]  col_new, col_old_q, col_mid_q;
  logic [DW-1:0]       near_rd, far_rd;

  always_comb begin
    near_rd    = lb_near[cur_col];
    far_rd     = lb_far[cur_col];
    col_new[0] = top_rep ? near_rd : far_rd;
    col_new[1] = near_rd;
    col_new[2] = bot_rep ? near_rd : pix;
  end

  // Row stores: data only, no reset
  always_ff @(posedge clk) begin
    if (beat) begin
      lb_near[cur_col] <= pix;
      lb_far[cur_col]  <= near_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_old_q <= '0;
      col_mid_q <= '0;
    end else if (beat) begin
      col_old_q <= col_mid_q;
      col_mid_q <= col_new;
    end
  end

  for (genvar gr = 0; gr < 3; gr++) begin : g_row
    assign win[gr][0] = left_rep  ? col_mid_q[gr] : col_old_q[gr];
    assign win[gr][1] = col_mid_q[gr];
    assign win[gr][2] = right_rep ? col_mid_q[gr] : col_new[gr];
  end
endmodule

// File: rtl/demosaic_interp.sv
module demosaic_interp #(
  parameter int                     DW    = 8,
  parameter bayer_pkg::bayer_phase_e PHASE = bayer_pkg::PH_RGGB
) (
  input  logic [2:0][2:0][DW-1:0] win,
  input  logic                    row_odd,
  input  logic                    col_odd,
  output logic [DW-1:0]           red,
  output logic [DW-1:0]           grn,
  output logic [DW-1:0]           blu
);
  timeunit 1ns; timeprecision 1ps;
  import bayer_pkg::*;

  localparam logic [1:0] PH_BITS = PHASE;

  site_e         site;
  logic [DW+1:0] sum_cross, sum_diag;
  logic [DW:0]   sum_hor, sum_ver;
  logic [DW-1:0] avg_cross, avg_diag, avg_hor, avg_ver, ctr;

  always_comb begin
    site = site_e'({row_odd ^ PH_BITS[1], col_odd ^ PH_BITS[0]});
    ctr  = win[1][1];

    sum_hor   = {1'b0, win[1][0]} + {1'b0, win[1][2]};
    sum_ver   = {1'b0, win[0][1]} + {1'b0, win[2][1]};
    sum_cross = {1'b0, sum_hor} + {1'b0, sum_ver};
    sum_diag  = {2'b00, win[0][0]} + {2'b00, win[0][2]} +
                {2'b00, win[2][0]} + {2'b00, win[2][2]};

    avg_hor   = sum_hor[DW:1];
    avg_ver   = sum_ver[DW:1];
    avg_cross = sum_cross[DW+1:2];
    avg_diag  = sum_diag[DW+1:2];

    unique case (site)
      SITE_RED:   begin red = ctr;      grn = avg_cross; blu = avg_diag; end
      SITE_G_RLN: begin red = avg_hor;  grn = ctr;       blu = avg_ver;  end
      SITE_G_BLN: begin red = avg_ver;  grn = ctr;       blu = avg_hor;  end
      default:    begin red = avg_diag; grn = avg_cross; blu = ctr;      end
    endcase
  end
endmodule

// File: rtl/demosaic_bilinear.sv
module demosaic_bilinear #(
  parameter int                      WIDTH  = 8,
  parameter int                      HEIGHT = 6,
  parameter int                      DW     = 8,
  parameter bayer_pkg::bayer_phase_e PHASE  = bayer_pkg::PH_RGGB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_pix,
  input  logic          in_sof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_red,
  output logic [DW-1:0] out_grn,
  output logic [DW-1:0] out_blu,
  output logic          out_sof,
  output logic          out_eol
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CW = $clog2(WIDTH);

  logic                      space, beat, emit;
  logic [CW-1:0]             cur_col;
  logic                      row_odd, col_odd, c_sof, c_eol;
  logic                      top_rep, bot_rep, left_rep, right_rep;
  logic [2:0][2:0][DW-1:0]   win;
  logic [DW-1:0]             r_w, g_w, b_w;

  logic                      vld_q, vld_d, sof_q, eol_q;
  logic [DW-1:0]             red_q, grn_q, blu_q;

  assign space = !vld_q || out_ready;

  demosaic_seq #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) seq_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .space(space), .in_ready(in_ready), .beat(beat), .cur_col(cur_col),
    .emit(emit), .ctr_row_odd(row_odd), .ctr_col_odd(col_odd),
    .ctr_sof(c_sof), .ctr_eol(c_eol), .top_rep(top_rep), .bot_rep(bot_rep),
    .left_rep(left_rep), .right_rep(right_rep)
  );

  demosaic_window #(.WIDTH(WIDTH), .DW(DW)) win_i (
    .clk(clk), .rst_n(rst_n), .beat(beat), .cur_col(cur_col), .pix(in_pix),
    .top_rep(top_rep), .bot_rep(bot_rep), .left_rep(left_rep),
    .right_rep(right_rep), .win(win)
  );

  demosaic_interp #(.DW(DW), .PHASE(PHASE)) interp_i (
    .win(win), .row_odd(row_odd), .col_odd(col_odd),
    .red(r_w), .grn(g_w), .blu(b_w)
  );

  // Output stage next state
  always_comb begin
    vld_d = vld_q;
    if (emit)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sof_q <= 1'b0;
      eol_q <= 1'b0;
      red_q <= '0;
      grn_q <= '0;
      blu_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (emit) begin
        sof_q <= c_sof;
        eol_q <= c_eol;
        red_q <= r_w;
        grn_q <= g_w;
        blu_q <= b_w;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_sof   = sof_q;
  assign out_eol   = eol_q;
  assign out_red   = red_q;
  assign out_grn   = grn_q;
  assign out_blu   = blu_q;
endmodule

// File: rtl/demosaic_bilinear_chk.sv
module demosaic_bilinear_chk #(
  parameter int WIDTH = 8,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_red,
  input logic [DW-1:0] out_grn,
  input logic [DW-1:0] out_blu,
  input logic          out_sof,
  input logic          out_eol
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CW = $clog2(WIDTH) + 1;

  logic [CW-1:0] ocol_q, ocol_eff;
  logic          xfer;

  assign xfer     = out_valid && out_ready;
  assign ocol_eff = out_sof ? '0 : ocol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ocol_q <= '0;
    else if (xfer) ocol_q <= out_eol ? '0 : ocol_eff + CW'(1);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_idle_r11: assert (!out_valid && in_ready);
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_red, out_grn, out_blu, out_sof, out_eol})));

  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_sof_not_eol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !out_eol);

  p_eol_position_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (out_eol == (ocol_eff == CW'(WIDTH - 1))));
endmodule

bind demosaic_bilinear demosaic_bilinear_chk #(.WIDTH(WIDTH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_red(out_red), .out_grn(out_grn),
  .out_blu(out_blu), .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/demosaic_bilinear_tb_top.sv
module demosaic_bilinear_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int W  = 8;
  localparam int H  = 6;
  localparam int DW = 8;
  localparam int NPIX = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_pix = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [DW-1:0] out_red, out_grn, out_blu;
  logic p_in_ready, p_out_valid, p_out_sof, p_out_eol;
  logic [DW-1:0] p_out_red, p_out_grn, p_out_blu;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  demosaic_bilinear #(.WIDTH(W), .HEIGHT(H), .DW(DW), .PHASE(bayer_pkg::PH_RGGB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
    .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu),
    .out_sof(out_sof), .out_eol(out_eol));

  demosaic_bilinear #(.WIDTH(W), .HEIGHT(H), .DW(DW), .PHASE(bayer_pkg::PH_GBRG)) dut_p (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(p_in_ready),
    .in_pix(in_pix), .in_sof(in_sof), .out_valid(p_out_valid), .out_ready(out_ready),
    .out_red(p_out_red), .out_grn(p_out_grn), .out_blu(p_out_blu),
    .out_sof(p_out_sof), .out_eol(p_out_eol));

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] img [H][W];
  logic [25:0] cap_i [2*NPIX];
  logic [25:0] cap_p [2*NPIX];
  int capc_i [2*NPIX];
  int acc_cyc [NPIX];
  int n_i = 0, n_p = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_v = 1'b0, prev_r = 1'b0;
  logic [25:0] prev_d = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  function automatic int px(input int y, input int x);
    return int'(img[clampi(y, H-1)][clampi(x, W-1)]);
  endfunction

  // Reference: bilinear with clamped neighbours; returns {r,g,b}
  function automatic logic [23:0] model(input int ph, input int y, input int x);
    int c, cr, dg, hz, vt, sy, sx;
    logic [7:0] r, g, b;
    c  = px(y, x);
    hz = (px(y, x-1) + px(y, x+1)) / 2;
    vt = (px(y-1, x) + px(y+1, x)) / 2;
    cr = (px(y, x-1) + px(y, x+1) + px(y-1, x) + px(y+1, x)) / 4;
    dg = (px(y-1, x-1) + px(y-1, x+1) + px(y+1, x-1) + px(y+1, x+1)) / 4;
    sy = (y % 2) ^ ((ph >> 1) & 1);
    sx = (x % 2) ^ (ph & 1);
    if (sy == 0 && sx == 0)      begin r = 8'(c);  g = 8'(cr); b = 8'(dg); end
    else if (sy == 1 && sx == 1) begin r = 8'(dg); g = 8'(cr); b = 8'(c);  end
    else if (sy == 0)            begin r = 8'(hz); g = 8'(c);  b = 8'(vt); end
    else                         begin r = 8'(vt); g = 8'(c);  b = 8'(hz); end
    return {r, g, b};
  endfunction

  function automatic string tag_of(input int ph, input int y, input int x);
    int sy, sx;
    if (ph != 0) return "R5";
    if (y == 0 || y == H-1 || x == 0 || x == W-1) return "R6";
    sy = (y % 2); sx = (x % 2);
    if (sy == 0 && sx == 0) return "R2";
    if (sy == 1 && sx == 1) return "R4";
    return "R3";
  endfunction

  // One cycle: drive at negedge, then sample once combinational paths settle
  task automatic tick(input logic iv, input logic [DW-1:0] pv, input logic sf,
                      input logic ordy, output logic acc, output logic rdy, output int cnow);
    @(negedge clk);
    in_valid = iv; in_pix = pv; in_sof = sf; out_ready = ordy;
    #1;
    cnow = cyc;
    rdy  = in_ready;
    acc  = iv && in_ready;
    if (prev_v && !prev_r)
      chk(out_valid && ({out_sof, out_eol, out_red, out_grn, out_blu} == prev_d),
          "R8", "held output", {6'd0, out_sof, out_eol, out_red, out_grn, out_blu}, {6'd0, prev_d});
    prev_v = out_valid; prev_r = out_ready;
    prev_d = {out_sof, out_eol, out_red, out_grn, out_blu};
    if (out_valid && out_ready && n_i < 2*NPIX) begin
      cap_i[n_i] = {out_sof, out_eol, out_red, out_grn, out_blu};
      capc_i[n_i] = cyc;
      n_i++;
    end
    if (p_out_valid && out_ready && n_p < 2*NPIX) begin
      cap_p[n_p] = {p_out_sof, p_out_eol, p_out_red, p_out_grn, p_out_blu};
      n_p++;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic fill(input int kind);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        case (kind)
          0: img[y][x] = 8'((y*29 + x*13 + x*y*7) & 255);
          1: img[y][x] = ((x + y) % 2 == 1) ? 8'd255 : 8'd0;
          2: img[y][x] = 8'd255;
          default: img[y][x] = 8'(((x*y*41 + y*5 + x*97) ^ (y << 4)) & 255);
        endcase
  endtask

  // Streams the image; stall=1 inserts pseudo-random gaps on both sides
  task automatic send_frame(input bit stall, output int low_cnt);
    logic acc, rdy, iv, ordy;
    int idx, guard, cn;
    idx = 0; guard = 0; low_cnt = 0; n_i = 0; n_p = 0;
    while (idx < NPIX && guard < 5000) begin
      iv   = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      ordy = stall ? (lfsr[5] | lfsr[9]) : 1'b1;
      tick(iv, img[idx / W][idx % W], idx == 0, ordy, acc, rdy, cn);
      if (acc) begin acc_cyc[idx] = cn; idx++; end
      guard++;
    end
    while (n_i < NPIX && guard < 5000) begin
      ordy = stall ? (lfsr[5] | lfsr[9]) : 1'b1;
      tick(1'b0, '0, 1'b0, ordy, acc, rdy, cn);
      if (!rdy) low_cnt++;
      guard++;
    end
    tick(1'b0, '0, 1'b0, 1'b1, acc, rdy, cn);
  endtask

  task automatic check_frame();
    logic [23:0] e;
    chk(n_i == NPIX, "R1", "output count", n_i, NPIX);
    chk(n_p == NPIX, "R5", "output count phase 2", n_p, NPIX);
    for (int k = 0; k < NPIX && k < n_i; k++) begin
      e = model(0, k / W, k % W);
      chk(cap_i[k][23:0] == e, tag_of(0, k / W, k % W), "pixel rgb", cap_i[k][23:0], e);
      chk(cap_i[k][25:24] == {k == 0, (k % W) == W-1}, "R9", "markers",
          cap_i[k][25:24], {k == 0, (k % W) == W-1});
    end
    for (int k = 0; k < NPIX && k < n_p; k++) begin
      e = model(2, k / W, k % W);
      chk(cap_p[k][23:0] == e, tag_of(2, k / W, k % W), "pixel rgb phase 2", cap_p[k][23:0], e);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R11", "out_valid in reset", out_valid, 0);
    chk(in_ready, "R11", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_streaming();
    int low;
    fill(0);
    send_frame(1'b0, low);
    check_frame();
    for (int k = 0; k < NPIX && k < n_i; k++)
      chk(capc_i[k] == acc_cyc[0] + k + W + 2, "R7", "output cycle",
          capc_i[k], acc_cyc[0] + k + W + 2);
    chk(low == W + 1, "R7", "drain cycles with in_ready low", low, W + 1);
    chk(acc_cyc[NPIX-1] == acc_cyc[0] + NPIX - 1, "R8", "one sample per cycle",
        acc_cyc[NPIX-1] - acc_cyc[0], NPIX - 1);
  endtask

  task automatic t_stalled();
    int low;
    fill(3);
    send_frame(1'b1, low);
    check_frame();
  endtask

  task automatic t_extremes();
    int low;
    fill(1);
    send_frame(1'b0, low);
    check_frame();
    fill(2);
    send_frame(1'b1, low);
    check_frame();
  endtask

  task automatic t_idle_and_resync();
    logic acc, rdy;
    int cn, low;
    n_i = 0;
    for (int i = 0; i < 5; i++) begin
      tick(1'b1, 8'(i * 50), 1'b0, 1'b1, acc, rdy, cn);
      chk(acc, "R10", "idle sample taken", acc, 1);
    end
    for (int i = 0; i < 12; i++) tick(1'b0, '0, 1'b0, 1'b1, acc, rdy, cn);
    chk(n_i == 0, "R10", "outputs from idle samples", n_i, 0);
    // aborted short frame, then a fresh one
    for (int i = 0; i < 3; i++) tick(1'b1, 8'(200 - i), i == 0, 1'b1, acc, rdy, cn);
    fill(0);
    send_frame(1'b0, low);
    chk(n_i == NPIX, "R10", "outputs after restart", n_i, NPIX);
    check_frame();
  endtask

  initial begin
    #1 rst_n = 1'b0;
    t_reset();
    t_streaming();
    t_stalled();
    t_extremes();
    t_idle_and_resync();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule